// File: doc/BRIEF.md
# I/O-Mapped Flash Programming Port

This block lets an 8-bit host reach a byte-wide parallel ROM or flash device using ordinary I/O read and write cycles. Four I/O ports are decoded. A control/status port starts a software init, toggles a diagnostic LED and switches address post-increment on or off. A presence-test port returns a transformed copy of what was last written to it. An address port accepts the 19-bit memory address one byte per write. A data window port turns each host read or write into exactly one memory read or write cycle at the current address.

The host strobes are active low and asynchronous to the block clock. They are synchronised before use. Each host cycle is a single transfer with no handshake and no back-pressure: the host holds IORQ and RD or WR low for at least `SYNC_STAGES + PULSE_CYCLES + 4` clocks. A data-port access that arrives while a memory cycle is still running is dropped. After reset, and after each software init, the block stays busy for `INIT_CYCLES` clocks. It then clears its state and reports the init as finished.

Top module: `fpp_port`

## Requirements
- R1: After reset the LED is 0, every memory strobe is high, no bus is driven, and the busy flag (status bit 7) reads 1 until the power-up init has finished.
- R2: A read of port 0x33 returns bit 7 = init busy, bit 6 = LED, bit 5 = auto-increment enable and 0 in bits 4..0. A write to 0x33 with bit 7 set starts a new init, and bit 7 then reads 1 until that init ends.
- R3: A write to 0x33 with bit 6 set inverts the LED. A write with bit 6 clear leaves the LED unchanged.
- R4: Bit 5 of every write to 0x33 becomes the auto-increment enable. With the enable at 0, repeated data-port accesses use the same address.
- R5: Each write of byte D to port 0x3B turns the 9-bit test value V into {~D, V[8]}. A read of 0x3B returns V[7:0].
- R6: Writes to port 0xB3 load the address one byte at a time: the first write sets bits 7..0, the second sets bits 15..8 and the third sets bits 18..16 from data bits 2..0. The fourth write then sets bits 7..0 again.
- R7: The byte position for port 0xB3 returns to the low byte after any read or write of port 0xBB, and after a write to 0x33 with bit 7 set.
- R8: A write of D to port 0xBB produces exactly one memory write of D at the current address.
- R9: A read of port 0xBB produces exactly one memory read at the current address. The host sees the byte read from memory.
- R10: While auto-increment is enabled, the address steps by one, modulo 2^19, after each data-port access.
- R11: Chip enable is low only during a memory cycle. Output enable and write enable are never low together, and the address stays stable while chip enable is low. Write enable rises while chip enable is still low. The memory data bus is driven only during write cycles.
- R12: Accesses to any other I/O address change no state and start no memory cycle. The host data bus is driven only while a read of a decoded port is in progress.
- R13: When an init finishes, the address, the byte position, the auto-increment enable, the LED and the test value are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 8 | Host I/O address |
| io_wdata | input | 8 | Host write data |
| io_iorq_n | input | 1 | Host I/O request strobe, active low |
| io_rd_n | input | 1 | Host read strobe, active low |
| io_wr_n | input | 1 | Host write strobe, active low |
| io_rdata | output | 8 | Host read data |
| io_rdata_oe | output | 1 | Host read data drive enable |
| mem_addr | output | 19 | Memory address |
| mem_din | input | 8 | Data returned by the memory |
| mem_dout | output | 8 | Data driven toward the memory |
| mem_dout_oe | output | 1 | Memory data drive enable |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| led | output | 1 | Diagnostic LED |

## Verification
Address loading is tried with three bytes, with four bytes (to show the wrap of the byte position) and with a single byte after a data access or an init (to show the position reset). Each of these gives a different memory address for the following data cycle. Data cycles run with auto-increment both on and off across the top of the 19-bit space, which separates a stepping address from a held one and also shows the modulo wrap. Reads of written and unwritten locations compare host data with a memory model. The presence port gets bytes with different top bits, so the rotate is distinguishable from a plain inversion. A stray port access sits between known reads to show that nothing moved.

// File: rtl/fpp_pkg.sv
package fpp_pkg;
  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_ACT  = 2'd1,
    MS_HOLD = 2'd2
  } mseq_state_t;
endpackage

// File: rtl/fpp_sync.sv
module fpp_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else if (s == 0) chain[s] <= d_in;
      else chain[s] <= chain[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/fpp_memseq.sv
module fpp_memseq
  import fpp_pkg::*;
#(
  parameter int DW           = 8,
  parameter int PULSE_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          write,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] mem_din,
  output logic          idle,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] mem_dout,
  output logic          mem_dout_oe,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);

  mseq_state_t   state_q;
  logic [CW-1:0] cnt_q;
  logic          wr_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MS_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata   <= '0;
    end else begin
      case (state_q)
        MS_IDLE: if (start) begin
          state_q <= MS_ACT;
          cnt_q   <= CW'(PULSE_CYCLES - 1);
          wr_q    <= write;
          wdata_q <= wdata;
        end
        MS_ACT: begin
          if (cnt_q == '0) begin
            if (!wr_q) rdata <= mem_din;
            state_q <= MS_HOLD;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: begin
          state_q <= MS_IDLE;
          wr_q    <= 1'b0;
        end
      endcase
    end
  end

  assign idle        = (state_q == MS_IDLE);
  assign done        = (state_q == MS_HOLD);
  assign mem_ce_n    = (state_q == MS_IDLE);
  assign mem_oe_n    = !((state_q == MS_ACT) && !wr_q);
  assign mem_we_n    = !((state_q == MS_ACT) && wr_q);
  assign mem_dout_oe = wr_q && (state_q != MS_IDLE);
  assign mem_dout    = wdata_q;

  // R11
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  // R11
  we_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_ce_n);
  // R11
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dout_oe);
endmodule

// File: rtl/fpp_regs.sv
module fpp_regs #(
  parameter int         AW          = 19,
  parameter int         DW          = 8,
  parameter int         IOAW        = 8,
  parameter logic [7:0] CTRL_PORT   = 8'h33,
  parameter logic [7:0] TEST_PORT   = 8'h3B,
  parameter logic [7:0] ADDR_PORT   = 8'hB3,
  parameter logic [7:0] DATA_PORT   = 8'hBB,
  parameter int         INIT_CYCLES = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_start,
  input  logic            rd_start,
  input  logic            rd_act,
  input  logic [IOAW-1:0] io_addr,
  input  logic [DW-1:0]   io_wdata,
  input  logic            io_iorq_n,
  input  logic            io_rd_n,
  input  logic            mem_idle,
  input  logic            mem_done,
  input  logic [DW-1:0]   mem_rdata,
  output logic [AW-1:0]   addr_o,
  output logic            led_o,
  output logic            mem_start,
  output logic            mem_write,
  output logic [DW-1:0]   mem_wdata,
  output logic [DW-1:0]   io_rdata,
  output logic            io_rdata_oe
);
  localparam int NB = (AW + 7) / 8;
  localparam int PW = (NB > 1) ? $clog2(NB) : 1;
  localparam int CW = $clog2(INIT_CYCLES + 1);

  logic [AW-1:0]   addr_q;
  logic [PW-1:0]   phase_q;
  logic [CW-1:0]   cnt_q;
  logic            busy_q, ai_q, led_q;
  logic [DW:0]     pres_q;
  logic [NB*8-1:0] addr_next;
  logic            hit_ctrl, hit_test, hit_addr, hit_data;

  assign hit_ctrl = (io_addr == IOAW'(CTRL_PORT));
  assign hit_test = (io_addr == IOAW'(TEST_PORT));
  assign hit_addr = (io_addr == IOAW'(ADDR_PORT));
  assign hit_data = (io_addr == IOAW'(DATA_PORT));

  always_comb begin
    addr_next = '0;
    addr_next[AW-1:0] = addr_q;
    addr_next[int'(phase_q)*8 +: 8] = io_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b1;
      cnt_q     <= CW'(INIT_CYCLES - 1);
      addr_q    <= '0;
      phase_q   <= '0;
      ai_q      <= 1'b0;
      led_q     <= 1'b0;
      pres_q    <= '0;
      mem_start <= 1'b0;
      mem_write <= 1'b0;
      mem_wdata <= '0;
    end else begin
      mem_start <= 1'b0;
      if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q  <= 1'b0;
          addr_q  <= '0;
          phase_q <= '0;
          ai_q    <= 1'b0;
          led_q   <= 1'b0;
          pres_q  <= '0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      if (mem_done && ai_q) addr_q <= addr_q + AW'(1);
      if (wr_start) begin
        if (hit_ctrl) begin
          ai_q <= io_wdata[5];
          if (io_wdata[6]) led_q <= ~led_q;
          if (io_wdata[7]) begin
            busy_q  <= 1'b1;
            cnt_q   <= CW'(INIT_CYCLES - 1);
            phase_q <= '0;
          end
        end
        if (hit_test) pres_q <= {~io_wdata, pres_q[DW]};
        if (hit_addr) begin
          addr_q  <= addr_next[AW-1:0];
          phase_q <= (phase_q == PW'(NB - 1)) ? '0 : phase_q + 1'b1;
        end
        if (hit_data) begin
          phase_q <= '0;
          if (mem_idle) begin
            mem_start <= 1'b1;
            mem_write <= 1'b1;
            mem_wdata <= io_wdata;
          end
        end
      end
      if (rd_start && hit_data) begin
        phase_q <= '0;
        if (mem_idle) begin
          mem_start <= 1'b1;
          mem_write <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    io_rdata = '0;
    if (hit_ctrl) io_rdata = DW'({busy_q, led_q, ai_q, 5'b00000});
    else if (hit_test) io_rdata = pres_q[DW-1:0];
    else if (hit_data) io_rdata = mem_rdata;
  end

  assign io_rdata_oe = rd_act && !io_iorq_n && !io_rd_n &&
                       (hit_ctrl || hit_test || hit_data);
  assign addr_o = addr_q;
  assign led_o  = led_q;

  // R13
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (addr_q == '0 && !ai_q && !led_q && pres_q == '0));
  // R10
  autoinc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_done && ai_q && !wr_start && !busy_q) |=> addr_q == $past(addr_q) + AW'(1));
  // R7
  phase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && hit_data) |=> phase_q == '0);
endmodule

// File: rtl/fpp_port.sv
module fpp_port #(
  parameter int         AW           = 19,
  parameter int         DW           = 8,
  parameter int         IOAW         = 8,
  parameter logic [7:0] CTRL_PORT    = 8'h33,
  parameter logic [7:0] TEST_PORT    = 8'h3B,
  parameter logic [7:0] ADDR_PORT    = 8'hB3,
  parameter logic [7:0] DATA_PORT    = 8'hBB,
  parameter int         SYNC_STAGES  = 2,
  parameter int         PULSE_CYCLES = 4,
  parameter int         INIT_CYCLES  = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IOAW-1:0] io_addr,
  input  logic [DW-1:0]   io_wdata,
  input  logic            io_iorq_n,
  input  logic            io_rd_n,
  input  logic            io_wr_n,
  output logic [DW-1:0]   io_rdata,
  output logic            io_rdata_oe,
  output logic [AW-1:0]   mem_addr,
  input  logic [DW-1:0]   mem_din,
  output logic [DW-1:0]   mem_dout,
  output logic            mem_dout_oe,
  output logic            mem_ce_n,
  output logic            mem_oe_n,
  output logic            mem_we_n,
  output logic            led
);
  logic [2:0]    strb_s;
  logic          rd_act, wr_act, rd_prev, wr_prev, rd_start, wr_start;
  logic          m_start, m_write, m_idle, m_done;
  logic [DW-1:0] m_wdata, m_rdata;

  fpp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_in({~io_iorq_n, ~io_rd_n, ~io_wr_n}),
    .q_out(strb_s)
  );

  assign rd_act = strb_s[2] & strb_s[1];
  assign wr_act = strb_s[2] & strb_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev <= 1'b0;
      wr_prev <= 1'b0;
    end else begin
      rd_prev <= rd_act;
      wr_prev <= wr_act;
    end
  end

  assign rd_start = rd_act & ~rd_prev;
  assign wr_start = wr_act & ~wr_prev;

  fpp_regs #(
    .AW(AW), .DW(DW), .IOAW(IOAW), .CTRL_PORT(CTRL_PORT), .TEST_PORT(TEST_PORT),
    .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT), .INIT_CYCLES(INIT_CYCLES)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .rd_start(rd_start),
    .rd_act(rd_act), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_iorq_n(io_iorq_n), .io_rd_n(io_rd_n), .mem_idle(m_idle),
    .mem_done(m_done), .mem_rdata(m_rdata), .addr_o(mem_addr), .led_o(led),
    .mem_start(m_start), .mem_write(m_write), .mem_wdata(m_wdata),
    .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe)
  );

  fpp_memseq #(.DW(DW), .PULSE_CYCLES(PULSE_CYCLES)) u_mseq (
    .clk(clk), .rst_n(rst_n), .start(m_start), .write(m_write),
    .wdata(m_wdata), .mem_din(mem_din), .idle(m_idle), .done(m_done),
    .rdata(m_rdata), .mem_dout(mem_dout), .mem_dout_oe(mem_dout_oe),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
  );

  // R11
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
endmodule

// File: tb/fpp_port_test.sv
`timescale 1ns/1ps
module fpp_port_test;
  localparam int HOLD = 16;
  localparam int MASK = 32'h7FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  io_addr = 8'h00, io_wdata = 8'h00;
  logic        io_iorq_n = 1'b1, io_rd_n = 1'b1, io_wr_n = 1'b1;
  logic [7:0]  io_rdata;
  logic        io_rdata_oe;
  logic [18:0] mem_addr;
  logic [7:0]  mem_din = 8'h00;
  logic [7:0]  mem_dout;
  logic        mem_dout_oe, mem_ce_n, mem_oe_n, mem_we_n, led;

  always #2.5 clk = ~clk;

  fpp_port uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_iorq_n(io_iorq_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
    .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe), .mem_addr(mem_addr),
    .mem_din(mem_din), .mem_dout(mem_dout), .mem_dout_oe(mem_dout_oe),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .led(led)
  );

  int checks = 0, failures = 0;
  bit quiet = 1'b0, bb_busy = 1'b0, init_pend = 1'b1, done = 1'b0;
  int exp_addr = 0, exp_phase = 0;
  bit exp_ai = 1'b0, exp_led = 1'b0;
  logic [8:0] exp_pres = 9'h0;
  logic [7:0] exp_mem [int];
  logic [7:0] chip_mem [int];
  int exp_wr_q [$];
  bit we_seen = 1'b0;
  int last_a = 0;
  logic [7:0] last_d = 8'h00;

  function automatic logic [7:0] dflt(int a);
    return a[7:0] ^ 8'hA5;
  endfunction

  function automatic logic [7:0] exp_rd(int a);
    return exp_mem.exists(a) ? exp_mem[a] : dflt(a);
  endfunction

  function automatic logic [7:0] chip_rd(int a);
    return chip_mem.exists(a) ? chip_mem[a] : dflt(a);
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // cycle-by-cycle comparison against the behavioural model and the memory model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(!mem_oe_n && !mem_we_n), "R11 oe/we overlap", {mem_oe_n, mem_we_n}, 3);
      chk(!(mem_ce_n && (!mem_oe_n || !mem_we_n || mem_dout_oe)), "R11 strobe without ce",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_dout_oe}, 4'b1110);
      chk(!(!mem_ce_n && !bb_busy), "R12 memory cycle outside data port", mem_ce_n, 1);
      if (quiet) begin
        chk(led === exp_led, "R3 led vs model", led, exp_led);
        chk(io_rdata_oe === 1'b0, "R12 host bus driven while idle", io_rdata_oe, 0);
      end
      if (!mem_we_n) begin
        chk(mem_dout_oe === 1'b1, "R11 data not driven in write", mem_dout_oe, 1);
        last_a  = int'(mem_addr);
        last_d  = mem_dout;
        we_seen = 1'b1;
      end else if (we_seen) begin
        we_seen = 1'b0;
        chip_mem[last_a] = last_d;
        if (exp_wr_q.size() == 0) begin
          chk(1'b0, "R8 unexpected memory write", (last_a << 8) | last_d, 0);
        end else begin
          int e;
          e = exp_wr_q.pop_front();
          chk(((last_a << 8) | last_d) == e, "R8/R6 memory write addr/data",
              (last_a << 8) | last_d, e);
        end
      end
      mem_din <= chip_rd(int'(mem_addr));
    end
  end

  task automatic iowr(input logic [7:0] a, input logic [7:0] d);
    quiet = 1'b0;
    if (a == 8'h33) begin
      exp_ai = d[5];
      if (d[6]) exp_led = ~exp_led;
      if (d[7]) begin exp_phase = 0; init_pend = 1'b1; end
    end else if (a == 8'h3B) begin
      exp_pres = {~d, exp_pres[8]};
    end else if (a == 8'hB3) begin
      exp_addr = exp_addr & ~(32'hFF << (exp_phase * 8));
      exp_addr = (exp_addr | (int'(d) << (exp_phase * 8))) & MASK;
      exp_phase = (exp_phase == 2) ? 0 : exp_phase + 1;
    end else if (a == 8'hBB) begin
      bb_busy = 1'b1;
      exp_wr_q.push_back((exp_addr << 8) | d);
      exp_mem[exp_addr] = d;
      if (exp_ai) exp_addr = (exp_addr + 1) & MASK;
      exp_phase = 0;
    end
    @(negedge clk);
    io_addr = a; io_wdata = d; io_iorq_n = 1'b0; io_wr_n = 1'b0;
    repeat (HOLD) @(negedge clk);
    io_iorq_n = 1'b1; io_wr_n = 1'b1;
    repeat (6) @(negedge clk);
    bb_busy = 1'b0;
    quiet = !init_pend;
  endtask

  task automatic iord(input logic [7:0] a, output logic [7:0] v, output logic oe);
    quiet = 1'b0;
    if (a == 8'hBB) bb_busy = 1'b1;
    @(negedge clk);
    io_addr = a; io_iorq_n = 1'b0; io_rd_n = 1'b0;
    repeat (HOLD - 1) @(negedge clk);
    v = io_rdata; oe = io_rdata_oe;
    @(negedge clk);
    io_iorq_n = 1'b1; io_rd_n = 1'b1;
    repeat (6) @(negedge clk);
    if (a == 8'hBB) begin
      if (exp_ai) exp_addr = (exp_addr + 1) & MASK;
      exp_phase = 0;
    end
    bb_busy = 1'b0;
    quiet = !init_pend;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] e, input string req);
    logic [7:0] v;
    logic oe;
    iord(a, v, oe);
    chk(oe === 1'b1, {req, " read drive"}, oe, 1);
    chk(v === e, req, v, e);
  endtask

  task automatic data_rd_chk(input string req);
    rd_chk(8'hBB, exp_rd(exp_addr), req);
  endtask

  task automatic ctrl_chk(input string req);
    rd_chk(8'h33, {1'b0, exp_led, exp_ai, 5'b0}, req);
  endtask

  task automatic init_wait();
    logic [7:0] v;
    logic oe;
    bit ok = 1'b0;
    for (int i = 0; i < 100; i++) begin
      iord(8'h33, v, oe);
      if (!v[7]) begin ok = 1'b1; break; end
    end
    chk(ok, "R2 init busy bit clears", ok, 1);
    exp_addr = 0; exp_phase = 0; exp_ai = 1'b0; exp_led = 1'b0; exp_pres = 9'h0;
    init_pend = 1'b0;
    quiet = 1'b1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(led === 1'b0, "R1 led at reset", led, 0);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 memory strobes at reset",
        {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk(!mem_dout_oe && !io_rdata_oe, "R1 buses undriven at reset",
        {mem_dout_oe, io_rdata_oe}, 0);
    rst_n = 1'b1;
    // R1 busy immediately after reset
    rd_chk(8'h33, 8'h80, "R1 status busy after reset");
    init_wait();
    ctrl_chk("R2 status after init");
    rd_chk(8'h3B, 8'h00, "R5 test value zero after init");

    // R3 led toggling
    for (int i = 0; i < 3; i++) begin
      iowr(8'h33, 8'h40);
      chk(led === exp_led, "R3 led after toggle write", led, exp_led);
      ctrl_chk("R3 status led bit");
    end
    iowr(8'h33, 8'h00);
    chk(led === exp_led, "R3 led unchanged with bit6 clear", led, exp_led);

    // R5 presence register
    iowr(8'h3B, 8'h3C); rd_chk(8'h3B, exp_pres[7:0], "R5 test after 3C");
    iowr(8'h3B, 8'hA5); rd_chk(8'h3B, exp_pres[7:0], "R5 test after A5");
    iowr(8'h3B, 8'h00); rd_chk(8'h3B, exp_pres[7:0], "R5 test after 00");
    iowr(8'h3B, 8'hFF); rd_chk(8'h3B, exp_pres[7:0], "R5 test after FF");

    // R6 three-byte load, R8 write, R9 read
    iowr(8'h33, 8'h00);
    iowr(8'hB3, 8'h34); iowr(8'hB3, 8'h12); iowr(8'hB3, 8'h05);
    chk(exp_addr == 32'h51234, "R6 model address", exp_addr, 32'h51234);
    iowr(8'hBB, 8'h5A);
    chk(mem_addr === 19'h51234, "R6 memory address after load", mem_addr, 32'h51234);
    data_rd_chk("R9 read back written byte");
    // R6 wrap on fourth byte
    iowr(8'hB3, 8'h11); iowr(8'hB3, 8'h22); iowr(8'hB3, 8'h07); iowr(8'hB3, 8'h99);
    chk(mem_addr === 19'h72299, "R6 fourth byte wraps to low byte", mem_addr, 32'h72299);
    data_rd_chk("R9 read unwritten location");
    // R7 byte position reset by data access
    iowr(8'hB3, 8'h40);
    data_rd_chk("R9 read after partial load");
    iowr(8'hB3, 8'h41);
    chk(mem_addr === 19'h72241, "R7 position reset by data read", mem_addr, 32'h72241);
    iowr(8'hBB, 8'hC3);
    iowr(8'hB3, 8'h55);
    iowr(8'h33, 8'h80);
    init_wait();
    iowr(8'hB3, 8'h66);
    chk(mem_addr === 19'h00066, "R7 position reset by init write", mem_addr, 32'h66);
    iowr(8'hBB, 8'h3C);

    // R4 / R10 auto-increment across the top of the space
    iowr(8'h33, 8'h20);
    ctrl_chk("R4 status auto-increment bit");
    iowr(8'hB3, 8'hFE); iowr(8'hB3, 8'hFF); iowr(8'hB3, 8'h07);
    iowr(8'hBB, 8'h01); iowr(8'hBB, 8'h02); iowr(8'hBB, 8'h03);
    chk(mem_addr === 19'h00001, "R10 address wrapped after three writes", mem_addr, 1);
    iowr(8'hB3, 8'hFE); iowr(8'hB3, 8'hFF); iowr(8'hB3, 8'h07);
    data_rd_chk("R10 read 1 with increment");
    data_rd_chk("R10 read 2 with increment");
    data_rd_chk("R10 read 3 with increment");
    iowr(8'h33, 8'h00);
    data_rd_chk("R4 read with increment off");
    data_rd_chk("R4 repeated read same address");
    chk(mem_addr === 19'h00001, "R4 address held", mem_addr, 1);

    // R12 undecoded port
    iowr(8'h44, 8'hFF);
    begin
      logic [7:0] v;
      logic oe;
      iord(8'h44, v, oe);
      chk(oe === 1'b0, "R12 undecoded read not driven", oe, 0);
    end
    ctrl_chk("R12 status unchanged by stray write");
    rd_chk(8'h3B, exp_pres[7:0], "R12 test value unchanged");
    chk(mem_addr === 19'h00001, "R12 address unchanged", mem_addr, 1);

    // R13 init clears everything
    iowr(8'h3B, 8'h12);
    iowr(8'h33, 8'h60);
    iowr(8'hB3, 8'h12);
    iowr(8'h33, 8'h80);
    init_wait();
    chk(led === 1'b0, "R13 led cleared", led, 0);
    chk(mem_addr === 19'h0, "R13 address cleared", mem_addr, 0);
    ctrl_chk("R13 status cleared");
    rd_chk(8'h3B, 8'h00, "R13 test value cleared");
    data_rd_chk("R13 read at address zero");
    chk(mem_addr === 19'h0, "R13 auto-increment cleared", mem_addr, 0);
    chk(exp_wr_q.size() == 0, "R8 all writes seen", exp_wr_q.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule